// File: doc/BRIEF.md
# Oversampling Serial Receiver with Three-Sample Voting

This block recovers asynchronous serial frames from a single receive line. An external baud generator supplies a one-cycle sample tick at a fixed multiple of the bit rate. The receiver looks for a low level on the line while idle and aligns a per-bit sample counter to it. It then decides every bit of the frame by a majority of three consecutive samples taken near the bit centre. This applies to the start bit, each data/parity bit and the stop bit. A start bit that votes high is treated as line noise, and the receiver goes back to waiting.

Two oversampling rates are available. The normal rate takes sixteen samples per bit. The double rate takes eight samples per bit. A frame carries between five and ten data-plus-parity bits and one stop bit. The decoded word and a frame-error flag are presented together with a one-cycle valid strobe. That strobe fires as soon as the stop bit has been voted, and the receiver is then ready at once for the next start bit. It does not wait for the rest of the stop bit.

Top module: `uart_mv_rx`

## Requirements
- R1: While `rst_n` is low and after release until the first frame, `rx_valid`, `frame_err` and `rx_word` are all 0.
- R2: With `dbl_speed` = 0, each bit spans 16 ticks counted from the first low tick (sample 1). The bit value is voted from samples 8, 9 and 10. Data bits arrive LSB first: received data bit i lands in `rx_word[i]`, and the bits above the frame length read 0.
- R3: With `dbl_speed` = 1, each bit spans 8 ticks, and the vote uses samples 4, 5 and 6 of each bit.
- R4: A bit value is the majority of its three voting samples. One disagreeing sample leaves the bit unchanged. Two disagreeing samples invert it.
- R5: `frame_err` is 1 when the stop bit votes 0 and 0 when it votes 1. It is updated together with the valid strobe and held until the next one.
- R6: `rx_valid` is high for exactly one clock per accepted frame. It rises on the clock after the tick that carries the last stop-bit voting sample.
- R7: If the start bit votes 1, no frame is reported, and the receiver waits for a new low sample.
- R8: In normal mode, a low sample on the tick right after stop-bit sample 10 starts a new frame. In double mode, stop-bit sample 7 is skipped, and a low from sample 8 onward starts a new frame.
- R9: `dbl_speed` and `frame_len` are captured only when a start is detected in idle. Changes during a frame do not affect it.
- R10: `frame_len` gives the number of data-plus-parity bits directly. Values below 5 act as 5, and values above 10 act as 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle sample strobe at 16x (normal) or 8x (double) the bit rate |
| rxd | input | 1 | Asynchronous serial line, idle high |
| dbl_speed | input | 1 | 1 selects 8 samples per bit, 0 selects 16 |
| frame_len | input | 4 | Data-plus-parity bit count, 5 to 10 |
| rx_word | output | 10 | Last received word, LSB = first data bit |
| rx_valid | output | 1 | One-cycle strobe for a completed frame |
| frame_err | output | 1 | Stop bit of the last frame voted 0 |

## Verification
The line passes through two synchroniser flops. For that reason the bench changes `rxd` three clocks before each tick, and every tick sees the level meant for it. The valid strobe, word and error flag are registered on the clock that carries the tick of the last stop-bit voting sample. That sample is sample 10 in normal mode and sample 6 in double mode. The bench therefore reads them at the falling edge just after that tick, and it checks one falling edge later that the strobe has dropped. Expected words come from the bench's own sample-level frame generator, which applies the majority rule and the length clamp arithmetically.

// File: rtl/uart_mv_pkg.sv
package uart_mv_pkg;
   typedef enum logic [2:0] {
      RX_IDLE  = 3'd0,
      RX_START = 3'd1,
      RX_DATA  = 3'd2,
      RX_STOP  = 3'd3,
      RX_GUARD = 3'd4
   } rx_state_e;
endpackage

// File: rtl/uart_mv_sync.sv
module uart_mv_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES < 1) begin : g_bad
         $error("uart_mv_sync: STAGES must be at least 1");
      end else if (STAGES == 1) begin : g_one
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b1;
            else        q <= din;
         end
         assign dout = q;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], din};
         end
         assign dout = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/uart_mv_vote.sv
module uart_mv_vote (
   input  logic clk,
   input  logic rst_n,
   input  logic cap_first,
   input  logic cap_mid,
   input  logic din,
   output logic maj
);
   logic s_a, s_b;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_a <= 1'b1;
         s_b <= 1'b1;
      end else begin
         if (cap_first) s_a <= din;
         if (cap_mid)   s_b <= din;
      end
   end

   // third sample is the live one on the deciding tick
   assign maj = (s_a & s_b) | (s_a & din) | (s_b & din);
endmodule

// File: rtl/uart_mv_ctrl.sv
module uart_mv_ctrl
   import uart_mv_pkg::*;
#(
   parameter int OS_NORM   = 16,
   parameter int OS_DBL    = 8,
   parameter int MIN_BITS  = 5,
   parameter int MAX_BITS  = 10,
   parameter int DBL_GUARD = 1,
   localparam int CNT_W = $clog2(OS_NORM + 1),
   localparam int LEN_W = $clog2(MAX_BITS + 1),
   localparam int IDX_W = $clog2(MAX_BITS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             rxd_s,
   input  logic             dbl_in,
   input  logic [LEN_W-1:0] len_in,
   input  logic             vote_bit,
   output logic             cap_first,
   output logic             cap_mid,
   output logic             frame_clr,
   output logic             data_ev,
   output logic             stop_ev,
   output logic [IDX_W-1:0] bit_idx,
   output logic             busy,
   output logic             cfg_dbl,
   output logic [LEN_W-1:0] cfg_len
);
   localparam int GW = $clog2(DBL_GUARD + 2);

   rx_state_e        st;
   logic [CNT_W-1:0] cnt, s_max, n_next, pos_f, pos_m, pos_l;
   logic [LEN_W-1:0] len_q, len_clamp;
   logic [IDX_W-1:0] bidx, last_idx;
   logic [GW-1:0]    gcnt;
   logic             dbl_q, active, samp, vote_ev, start_det;

   always_comb begin
      s_max  = dbl_q ? CNT_W'(OS_DBL) : CNT_W'(OS_NORM);
      pos_f  = s_max >> 1;
      pos_m  = pos_f + CNT_W'(1);
      pos_l  = pos_f + CNT_W'(2);
      n_next = (cnt == s_max) ? CNT_W'(1) : cnt + CNT_W'(1);
   end

   always_comb begin
      if (len_in < LEN_W'(MIN_BITS))      len_clamp = LEN_W'(MIN_BITS);
      else if (len_in > LEN_W'(MAX_BITS)) len_clamp = LEN_W'(MAX_BITS);
      else                                len_clamp = len_in;
   end

   assign active    = (st == RX_START) || (st == RX_DATA) || (st == RX_STOP);
   assign samp      = tick && active;
   assign cap_first = samp && (n_next == pos_f);
   assign cap_mid   = samp && (n_next == pos_m);
   assign vote_ev   = samp && (n_next == pos_l);
   assign start_det = tick && (st == RX_IDLE) && !rxd_s;
   assign frame_clr = start_det;
   assign data_ev   = vote_ev && (st == RX_DATA);
   assign stop_ev   = vote_ev && (st == RX_STOP);
   assign last_idx  = IDX_W'(len_q - LEN_W'(1));
   assign bit_idx   = bidx;
   assign busy      = (st != RX_IDLE);
   assign cfg_dbl   = dbl_q;
   assign cfg_len   = len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= RX_IDLE;
         cnt   <= '0;
         bidx  <= '0;
         dbl_q <= 1'b0;
         len_q <= LEN_W'(MIN_BITS);
         gcnt  <= '0;
      end else begin
         case (st)
            RX_IDLE: begin
               if (start_det) begin
                  st    <= RX_START;
                  cnt   <= CNT_W'(1);
                  bidx  <= '0;
                  dbl_q <= dbl_in;
                  len_q <= len_clamp;
               end
            end
            RX_START: begin
               if (samp) cnt <= n_next;
               if (vote_ev) st <= vote_bit ? RX_IDLE : RX_DATA;
            end
            RX_DATA: begin
               if (samp) cnt <= n_next;
               if (vote_ev) begin
                  bidx <= bidx + IDX_W'(1);
                  if (bidx == last_idx) st <= RX_STOP;
               end
            end
            RX_STOP: begin
               if (samp) cnt <= n_next;
               if (vote_ev) begin
                  if (dbl_q && (DBL_GUARD > 0)) begin
                     st   <= RX_GUARD;
                     gcnt <= GW'(DBL_GUARD);
                  end else begin
                     st <= RX_IDLE;
                  end
               end
            end
            RX_GUARD: begin
               if (tick) begin
                  gcnt <= gcnt - GW'(1);
                  if (gcnt <= GW'(1)) st <= RX_IDLE;
               end
            end
            default: st <= RX_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/uart_mv_rx.sv
module uart_mv_rx #(
   parameter int OS_NORM     = 16,
   parameter int OS_DBL      = 8,
   parameter int MIN_BITS    = 5,
   parameter int MAX_BITS    = 10,
   parameter int SYNC_STAGES = 2,
   parameter int DBL_GUARD   = 1,
   localparam int LEN_W = $clog2(MAX_BITS + 1),
   localparam int IDX_W = $clog2(MAX_BITS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic                rxd,
   input  logic                dbl_speed,
   input  logic [LEN_W-1:0]    frame_len,
   output logic [MAX_BITS-1:0] rx_word,
   output logic                rx_valid,
   output logic                frame_err
);
   generate
      if (OS_NORM < 6 || OS_DBL < 6 || OS_DBL > OS_NORM) begin : g_bad_os
         $error("uart_mv_rx: oversampling factors out of range");
      end
      if ((OS_NORM % 2) != 0 || (OS_DBL % 2) != 0) begin : g_odd_os
         $error("uart_mv_rx: oversampling factors must be even");
      end
      if (MIN_BITS < 1 || MAX_BITS < MIN_BITS) begin : g_bad_len
         $error("uart_mv_rx: frame length bounds invalid");
      end
      if (DBL_GUARD < 0 || DBL_GUARD >= OS_DBL / 2) begin : g_bad_guard
         $error("uart_mv_rx: guard ticks out of range");
      end
   endgenerate

   logic             rxd_s, maj;
   logic             cap_first, cap_mid, frame_clr, data_ev, stop_ev;
   logic             ctl_busy, ctl_dbl;
   logic [LEN_W-1:0] ctl_len;
   logic [IDX_W-1:0] bit_idx;
   logic [MAX_BITS-1:0] word_acc;

   uart_mv_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst_n (rst_n),
      .din (rxd),
      .dout (rxd_s)
   );

   uart_mv_vote u_vote (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_first (cap_first),
      .cap_mid   (cap_mid),
      .din       (rxd_s),
      .maj       (maj)
   );

   uart_mv_ctrl #(
      .OS_NORM   (OS_NORM),
      .OS_DBL    (OS_DBL),
      .MIN_BITS  (MIN_BITS),
      .MAX_BITS  (MAX_BITS),
      .DBL_GUARD (DBL_GUARD)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .rxd_s     (rxd_s),
      .dbl_in    (dbl_speed),
      .len_in    (frame_len),
      .vote_bit  (maj),
      .cap_first (cap_first),
      .cap_mid   (cap_mid),
      .frame_clr (frame_clr),
      .data_ev   (data_ev),
      .stop_ev   (stop_ev),
      .bit_idx   (bit_idx),
      .busy      (ctl_busy),
      .cfg_dbl   (ctl_dbl),
      .cfg_len   (ctl_len)
   );

   // word assembly, LSB first
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_acc <= '0;
      end else if (frame_clr) begin
         word_acc <= '0;
      end else if (data_ev) begin
         word_acc[bit_idx] <= maj;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_word   <= '0;
         rx_valid  <= 1'b0;
         frame_err <= 1'b0;
      end else begin
         rx_valid <= stop_ev;
         if (stop_ev) begin
            rx_word   <= word_acc;
            frame_err <= ~maj;
         end
      end
   end
endmodule

// File: rtl/uart_mv_rx_chk.sv
module uart_mv_rx_chk #(
   parameter int MIN_BITS = 5,
   parameter int MAX_BITS = 10,
   localparam int LEN_W = $clog2(MAX_BITS + 1)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                tick,
   input logic                rx_valid,
   input logic                frame_err,
   input logic [MAX_BITS-1:0] rx_word,
   input logic                busy,
   input logic                cfg_dbl,
   input logic [LEN_W-1:0]    cfg_len
);
   // R6: strobe lasts one clock
   a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   // R6: strobe only follows a sample tick
   a_r6_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> $past(tick));

   // R5: error flag changes only with a strobe
   a_r5_err_held: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |-> $stable(frame_err));

   // R2: word changes only with a strobe
   a_r2_word_held: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |-> $stable(rx_word));

   // R9: captured configuration frozen while a frame is in progress
   a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(cfg_dbl) && $stable(cfg_len)));

   // R10: captured length inside bounds
   a_r10_len_bounds: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_len >= LEN_W'(MIN_BITS)) && (cfg_len <= LEN_W'(MAX_BITS)));
endmodule

bind uart_mv_rx uart_mv_rx_chk #(
   .MIN_BITS (MIN_BITS),
   .MAX_BITS (MAX_BITS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick      (tick),
   .rx_valid  (rx_valid),
   .frame_err (frame_err),
   .rx_word   (rx_word),
   .busy      (ctl_busy),
   .cfg_dbl   (ctl_dbl),
   .cfg_len   (ctl_len)
);

// File: tb/tb_uart_mv_rx.sv
module tb_uart_mv_rx;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       rxd = 1'b1;
   logic       dbl = 1'b0;
   logic [3:0] flen = 4'd8;
   logic [9:0] rx_word;
   logic       rx_valid, frame_err;

   int checks = 0, errors = 0, vcount = 0;
   int cap_word = 0;
   int cap_err = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   uart_mv_rx dut (
      .clk (clk), .rst_n (rst_n), .tick (tick), .rxd (rxd),
      .dbl_speed (dbl), .frame_len (flen),
      .rx_word (rx_word), .rx_valid (rx_valid), .frame_err (frame_err)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // one sample: level held three clocks ahead of its tick
   task automatic samp(input logic lvl);
      @(negedge clk) rxd = lvl;
      repeat (2) @(negedge clk);
      tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      if (rx_valid) begin
         vcount++;
         cap_word = int'(rx_word);
         cap_err  = int'(frame_err);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) samp(1'b1);
   endtask

   // cbit: 0 start, 1..len data, len+1 stop; cmask flips voting samples
   task automatic send_frame(input bit d, input int len, input int word,
                             input bit stopv, input int stop_len,
                             input int cbit, input bit [2:0] cmask,
                             input bit flipcfg);
      int s = d ? 8 : 16;
      int f = s / 2;
      for (int b = 0; b <= len + 1; b++) begin
         logic lvl;
         int   ns;
         lvl = (b == 0) ? 1'b0 : (b <= len) ? logic'((word >> (b - 1)) & 1) : stopv;
         ns  = (b == len + 1) ? stop_len : s;
         for (int k = 1; k <= ns; k++) begin
            logic v;
            v = lvl;
            if (b == cbit) begin
               if (k == f     && cmask[0]) v = ~v;
               if (k == f + 1 && cmask[1]) v = ~v;
               if (k == f + 2 && cmask[2]) v = ~v;
            end
            samp(v);
            if (b == 0 && k == 1 && flipcfg) begin
               dbl  = ~dbl;
               flen = (len > 7) ? 4'd5 : 4'd10;
            end
         end
      end
   endtask

   task automatic expect_frame(input string tag, input int v0, input int ew, input int ee);
      chk(vcount == v0 + 1, {tag, " strobe count"}, vcount - v0, 1);
      chk(cap_word == ew, {tag, " word"}, cap_word, ew);
      chk(cap_err == ee, {tag, " frame_err"}, cap_err, ee);
      @(negedge clk);
      chk(rx_valid == 1'b0, {tag, " R6 strobe dropped"}, int'(rx_valid), 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int v0, w, ew, s;
      repeat (3) @(negedge clk);
      chk(rx_valid == 1'b0, "R1 reset valid", int'(rx_valid), 0);
      chk(frame_err == 1'b0, "R1 reset err", int'(frame_err), 0);
      chk(rx_word == 10'd0, "R1 reset word", int'(rx_word), 0);
      rst_n = 1'b1;
      idle(4);
      chk(vcount == 0 && rx_word == 10'd0, "R1 idle after reset", vcount, 0);

      // R2 / R3: sweep modes, lengths and patterns
      for (int d = 0; d < 2; d++) begin
         for (int l = 5; l <= 10; l++) begin
            for (int p = 0; p < 4; p++) begin
               s = d ? 8 : 16;
               case (p)
                  0: w = 0;
                  1: w = 1023;
                  2: w = 'h155;
                  default: w = (l * 37 + d * 91 + 5) & 1023;
               endcase
               dbl = d[0]; flen = 4'(l);
               v0 = vcount;
               send_frame(d[0], l, w, 1'b1, s, -1, 3'b000, 1'b0);
               idle(2);
               expect_frame(d ? "R3 sweep" : "R2 sweep", v0, w & ((1 << l) - 1), 0);
            end
         end
      end

      // R4: majority on data bit index 2 of 'hA5
      for (int d = 0; d < 2; d++) begin
         for (int m = 1; m < 8; m++) begin
            bit [2:0] mk;
            mk = 3'(m);
            s = d ? 8 : 16;
            dbl = d[0]; flen = 4'd8;
            ew = ($countones(mk) >= 2) ? ('hA5 ^ 4) : 'hA5;
            v0 = vcount;
            send_frame(d[0], 8, 'hA5, 1'b1, s, 3, mk, 1'b0);
            idle(2);
            expect_frame("R4 vote", v0, ew, 0);
         end
      end

      // R5: stop bit low gives frame error, no spurious frame after
      for (int d = 0; d < 2; d++) begin
         s = d ? 8 : 16;
         dbl = d[0]; flen = 4'd6;
         v0 = vcount;
         send_frame(d[0], 6, 'h2D, 1'b0, s, -1, 3'b000, 1'b0);
         idle(2 * s);
         expect_frame("R5 stop low", v0, 'h2D, 1);
         v0 = vcount;
         send_frame(d[0], 6, 'h12, 1'b1, s, -1, 3'b000, 1'b0);
         idle(2);
         expect_frame("R5 stop high", v0, 'h12, 0);
      end

      // R7: short low treated as glitch, then a clean frame
      for (int d = 0; d < 2; d++) begin
         s = d ? 8 : 16;
         dbl = d[0]; flen = 4'd7;
         v0 = vcount;
         for (int k = 0; k < s / 2; k++) samp(1'b0);
         idle(3 * s);
         chk(vcount == v0, "R7 glitch ignored", vcount - v0, 0);
         send_frame(d[0], 7, 'h4B, 1'b1, s, -1, 3'b000, 1'b0);
         idle(2);
         expect_frame("R7 after glitch", v0, 'h4B, 0);
      end

      // R8: next start right after stop votes (normal 10, double 6 + 1 skipped)
      for (int d = 0; d < 2; d++) begin
         s = d ? 8 : 16;
         dbl = d[0]; flen = 4'd9;
         v0 = vcount;
         send_frame(d[0], 9, 'h1C3, 1'b1, d ? 7 : 10, -1, 3'b000, 1'b0);
         chk(vcount == v0 + 1 && cap_word == 'h1C3, "R8 first frame", cap_word, 'h1C3);
         v0 = vcount;
         send_frame(d[0], 9, 'h0B6, 1'b1, s, -1, 3'b000, 1'b0);
         idle(2);
         expect_frame("R8 back-to-back", v0, 'h0B6, 0);
      end

      // R9: configuration changed mid-frame has no effect
      for (int d = 0; d < 2; d++) begin
         s = d ? 8 : 16;
         dbl = d[0]; flen = 4'd7;
         v0 = vcount;
         send_frame(d[0], 7, 'h59, 1'b1, s, -1, 3'b000, 1'b1);
         idle(2);
         expect_frame("R9 cfg frozen", v0, 'h59, 0);
      end

      // R10: out-of-range lengths clamp
      dbl = 1'b0; flen = 4'd3;
      v0 = vcount;
      send_frame(1'b0, 5, 'h15, 1'b1, 16, -1, 3'b000, 1'b0);
      idle(2);
      expect_frame("R10 clamp low", v0, 'h15, 0);
      flen = 4'd15;
      v0 = vcount;
      send_frame(1'b0, 10, 'h2E7, 1'b1, 16, -1, 3'b000, 1'b0);
      idle(2);
      expect_frame("R10 clamp high", v0, 'h2E7, 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule